// File: doc/BRIEF.md
# Sleep trap and wake-status control

This block holds the sleep and wake configuration of a power-management unit, reached over a small register bus. Software sets a sleep-go bit, together with a sleep-type code, to ask the platform to enter a sleep state. One control bit decides what that write does. With the bit clear, the write emits a one-cycle sleep request that carries the type code. With the bit set, the write raises a system-management interrupt (SMI) instead, so that firmware can step in before any sleep is sequenced.

Every sleep-go write also sets a sleep-trap status flag. The trap control bit only decides whether that flag drives the SMI output.

A second flag records wake-ups. It is always set by a falling edge on the active-low power-on input, which is first synchronized to the clock. A second control bit optionally lets any enabled wake-event source set the flag as well. A further control bit drives the power-enable line of an external low-frequency clock PLL.

Top module: `pm_sleep_trap`

## Requirements
- R1: The control register (address 0) resets to 0x00. Bit 0 is the trap enable, bit 1 is the wake-select, and bit 7 is the PLL enable; all three read back as written. Bits 6..2 always read 0 and ignore writes.
- R2: With trap enable 0, a write to address 1 with bit 7 set drives sleep_req_o high for exactly the one cycle after the write edge. In that same cycle, sleep_type_o equals bits 2..0 of the written data.
- R3: With trap enable 1, a sleep-go write leaves sleep_req_o low.
- R4: Every sleep-go write sets status bit 1 (sleep-trap flag) at address 2, whatever the trap enable is. smi_o is high exactly while status bit 1 and the trap enable are both 1, and it stays high until one of them is cleared.
- R5: Address 1 reads back the sleep-type code in bits 2..0; bit 7 (sleep-go) and bits 6..3 read 0.
- R6: A falling edge on por_ni sets status bit 0 (wake flag) on the third clock edge after the input changes, whatever the wake-select is. A rising edge has no effect.
- R7: With wake-select 0, wake_i events do not set the wake flag. With wake-select 1, a wake_i bit that is high at a clock edge sets the flag only if the matching enable bit is 1.
- R8: The status bits clear when a 1 is written to them; writing 0 has no effect. If a set and a clear of the same bit arrive in the same cycle, the bit stays set.
- R9: pll_pwr_o follows control bit 7.
- R10: The wake-enable register (address 3) holds NUM_WAKE bits and resets to 0. Bits above NUM_WAKE read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (battery-backed power-on reset) |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, 0 when no read is in progress |
| por_ni | input | 1 | Asynchronous active-low power-on input |
| wake_i | input | NUM_WAKE | Wake-event sources, synchronous level |
| sleep_req_o | output | 1 | One-cycle sleep request pulse |
| sleep_type_o | output | SLP_TYP_W | Programmed sleep-type code |
| smi_o | output | 1 | Level SMI output |
| pll_pwr_o | output | 1 | PLL power enable |

## Verification
The assertions check on every cycle that a sleep request only ever follows a sleep-go write made while the trap was off, and that a trapped write never produces one. They also check that every sleep-go write sets the trap flag, that the SMI and wake flag hold until a register write can touch them, and that the reserved control bits read 0. The bench's scenarios are the only place that shows the exact pulse width and the type code carried with it, and the three-edge latency of the power-on edge detector. The scenarios also cover how each wake source is gated by its enable and by the wake-select, set-over-clear priority, and the readback masking of every register.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_SLEEP = 2'd1,
    REG_STAT  = 2'd2,
    REG_WEN   = 2'd3
  } reg_addr_e;

  localparam int CTRL_TRAP_BIT  = 0;
  localparam int CTRL_WSEL_BIT  = 1;
  localparam int CTRL_PLL_BIT   = 7;
  localparam int SLEEP_GO_BIT   = 7;
  localparam int STAT_WAKE_BIT  = 0;
  localparam int STAT_SLP_BIT   = 1;
  localparam int NUM_STAT       = 2;

  typedef struct packed {
    logic pll;
    logic wsel;
    logic trap;
  } ctrl_t;
endpackage

// File: rtl/pm_por_edge.sv
module pm_por_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  output logic fall_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  // reset to the deasserted (high) level so no edge appears at release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], por_ni};
      prev_q <= sync_q[1];
    end
  end

  assign fall_o = prev_q & ~sync_q[1];
endmodule

// File: rtl/pm_status.sv
module pm_status #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_sleep_pkg::*;
#(
  parameter int NUM_WAKE  = 4,
  parameter int SLP_TYP_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_ctrl_i,
  input  logic                 wr_sleep_i,
  input  logic                 wr_wen_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output ctrl_t                ctrl_o,
  output logic [SLP_TYP_W-1:0] sleep_type_o,
  output logic [NUM_WAKE-1:0]  wake_en_o,
  output logic                 go_wr_o,
  output logic                 sleep_req_o
);
  assign go_wr_o = wr_sleep_i & wdata_i[SLEEP_GO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o       <= '0;
      sleep_type_o <= '0;
      wake_en_o    <= '0;
      sleep_req_o  <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        ctrl_o.trap <= wdata_i[CTRL_TRAP_BIT];
        ctrl_o.wsel <= wdata_i[CTRL_WSEL_BIT];
        ctrl_o.pll  <= wdata_i[CTRL_PLL_BIT];
      end
      if (wr_sleep_i) sleep_type_o <= wdata_i[SLP_TYP_W-1:0];
      if (wr_wen_i)   wake_en_o    <= wdata_i[NUM_WAKE-1:0];
      sleep_req_o <= go_wr_o & ~ctrl_o.trap;
    end
  end
endmodule

// File: rtl/pm_sleep_trap.sv
module pm_sleep_trap
  import pm_sleep_pkg::*;
#(
  parameter int NUM_WAKE  = 4,
  parameter int SLP_TYP_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 por_ni,
  input  logic [NUM_WAKE-1:0]  wake_i,
  output logic                 sleep_req_o,
  output logic [SLP_TYP_W-1:0] sleep_type_o,
  output logic                 smi_o,
  output logic                 pll_pwr_o
);
  localparam int WPAD = DATA_W - NUM_WAKE;
  localparam int TPAD = DATA_W - SLP_TYP_W;

  logic                wr, rd;
  logic                wr_ctrl, wr_sleep, wr_stat, wr_wen;
  ctrl_t               ctrl_q;
  logic [NUM_WAKE-1:0] wake_en;
  logic                go_wr, trap_en, por_fall, wake_hit;
  logic [NUM_STAT-1:0] stat_set, stat_clr, stat_q;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign wr_ctrl  = wr & (addr_i == REG_CTRL);
  assign wr_sleep = wr & (addr_i == REG_SLEEP);
  assign wr_stat  = wr & (addr_i == REG_STAT);
  assign wr_wen   = wr & (addr_i == REG_WEN);

  pm_cfg_regs #(.NUM_WAKE(NUM_WAKE), .SLP_TYP_W(SLP_TYP_W)) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctrl_i    (wr_ctrl),
    .wr_sleep_i   (wr_sleep),
    .wr_wen_i     (wr_wen),
    .wdata_i      (wdata_i),
    .ctrl_o       (ctrl_q),
    .sleep_type_o (sleep_type_o),
    .wake_en_o    (wake_en),
    .go_wr_o      (go_wr),
    .sleep_req_o  (sleep_req_o)
  );

  pm_por_edge i_por (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .por_ni (por_ni),
    .fall_o (por_fall)
  );

  assign wake_hit = ctrl_q.wsel & |(wake_i & wake_en);

  always_comb begin
    stat_set                = '0;
    stat_set[STAT_WAKE_BIT] = por_fall | wake_hit;
    stat_set[STAT_SLP_BIT]  = go_wr;
    stat_clr                = {NUM_STAT{wr_stat}} & wdata_i[NUM_STAT-1:0];
  end

  pm_status #(.N(NUM_STAT)) i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stat_set),
    .clr_i  (stat_clr),
    .q_o    (stat_q)
  );

  assign trap_en   = ctrl_q.trap;
  assign smi_o     = stat_q[STAT_SLP_BIT] & trap_en;
  assign pll_pwr_o = ctrl_q.pll;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        REG_CTRL: begin
          rdata_o[CTRL_TRAP_BIT] = ctrl_q.trap;
          rdata_o[CTRL_WSEL_BIT] = ctrl_q.wsel;
          rdata_o[CTRL_PLL_BIT]  = ctrl_q.pll;
        end
        REG_SLEEP: rdata_o = {{TPAD{1'b0}}, sleep_type_o};
        REG_STAT:  rdata_o[NUM_STAT-1:0] = stat_q;
        REG_WEN:   rdata_o = {{WPAD{1'b0}}, wake_en};
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pm_sleep_trap_chk.sv
module pm_sleep_trap_chk
  import pm_sleep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sleep_req_o,
  input logic              smi_o,
  input logic              trap_en,
  input logic              go_wr,
  input logic [1:0]        stat_q
);
  logic stat_wr, ctrl_wr, ctrl_rd;
  assign stat_wr = req_i & we_i & (addr_i == REG_STAT);
  assign ctrl_wr = req_i & we_i & (addr_i == REG_CTRL);
  assign ctrl_rd = req_i & ~we_i & (addr_i == REG_CTRL);

  assert_sleep_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_o |-> $past(go_wr && !trap_en));

  assert_trap_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && trap_en) |=> !sleep_req_o);

  assert_trap_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wr |=> stat_q[1]);

  assert_smi_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o && !stat_wr && !ctrl_wr) |=> smi_o);

  assert_wake_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && !(stat_wr && wdata_i[0])) |=> stat_q[0]);

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |-> (rdata_o[6:2] == 5'd0));
endmodule

bind pm_sleep_trap pm_sleep_trap_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .sleep_req_o (sleep_req_o),
  .smi_o       (smi_o),
  .trap_en     (trap_en),
  .go_wr       (go_wr),
  .stat_q      (stat_q)
);

// File: tb/test_pm_sleep_trap.sv
module test_pm_sleep_trap;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          por_ni = 1'b1;
  logic [NW-1:0] wake_i = '0;
  logic          sleep_req_o, smi_o, pll_pwr_o;
  logic [TW-1:0] sleep_type_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_sleep_trap #(.NUM_WAKE(NW), .SLP_TYP_W(TW)) i_pm_sleep_trap (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .por_ni(por_ni), .wake_i(wake_i), .sleep_req_o(sleep_req_o),
    .sleep_type_o(sleep_type_o), .smi_o(smi_o), .pll_pwr_o(pll_pwr_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // returns at the falling edge just after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv); check("R1 reset readback", rv, 8'h00);
    end
    check("R4 reset smi", {7'd0, smi_o}, 8'h00);
    check("R2 reset sleep_req", {7'd0, sleep_req_o}, 8'h00);
    check("R9 reset pll", {7'd0, pll_pwr_o}, 8'h00);

    // control register sweep: only bits 0,1,7 stick
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, v[7:0]);
      rd(2'd0, rv); check("R1 ctrl mask", rv, v[7:0] & 8'h83);
      check("R9 pll follows", {7'd0, pll_pwr_o}, {7'd0, v[7]});
    end
    wr(2'd0, 8'h00);

    // wake enable width
    wr(2'd3, 8'hFF);
    rd(2'd3, rv); check("R10 wen mask", rv, 8'h0F);

    // sleep-go sweep in both trap modes
    for (int trap = 0; trap < 2; trap++) begin
      wr(2'd0, {7'd0, trap[0]});
      for (int t = 0; t < 8; t++) begin
        wr(2'd1, 8'h80 | t[7:0]);
        check(trap ? "R3 trapped no req" : "R2 req pulse",
              {7'd0, sleep_req_o}, {7'd0, ~trap[0]});
        check("R2 type out", {5'd0, sleep_type_o}, t[7:0]);
        check("R4 smi level", {7'd0, smi_o}, {7'd0, trap[0]});
        @(negedge clk);
        check("R2 one cycle", {7'd0, sleep_req_o}, 8'h00);
        rd(2'd1, rv); check("R5 sleep readback", rv, t[7:0]);
        rd(2'd2, rv); check("R4 trap flag", rv & 8'h02, 8'h02);
        wr(2'd2, 8'h02);
        rd(2'd2, rv); check("R8 w1c clears", rv & 8'h02, 8'h00);
        check("R4 smi drops", {7'd0, smi_o}, 8'h00);
      end
    end

    // type write without go: no request
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h05);
    check("R2 no go no req", {7'd0, sleep_req_o}, 8'h00);
    rd(2'd2, rv); check("R4 no go no flag", rv, 8'h00);

    // smi as level of flag and enable
    wr(2'd1, 8'h80);
    check("R4 flag without trap", {7'd0, smi_o}, 8'h00);
    wr(2'd0, 8'h01);
    check("R4 smi on enable", {7'd0, smi_o}, 8'h01);
    repeat (3) @(negedge clk);
    check("R4 smi held", {7'd0, smi_o}, 8'h01);
    wr(2'd2, 8'h00);
    check("R8 zero write no effect", {7'd0, smi_o}, 8'h01);
    wr(2'd2, 8'h02);
    check("R4 smi cleared", {7'd0, smi_o}, 8'h00);

    // wake events with wake-select clear: ignored
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h0F);
    for (int s = 0; s < NW; s++) begin
      @(negedge clk); wake_i = NW'(1 << s);
      @(negedge clk); wake_i = '0;
      rd(2'd2, rv); check("R7 wsel off ignores", rv & 8'h01, 8'h00);
    end

    // wake-select set: every enable pattern against every source
    wr(2'd0, 8'h02);
    for (int en = 0; en < 16; en++) begin
      wr(2'd3, en[7:0]);
      for (int s = 0; s < NW; s++) begin
        @(negedge clk); wake_i = NW'(1 << s);
        @(negedge clk); wake_i = '0;
        rd(2'd2, rv); check("R7 enabled source", rv & 8'h01, {7'd0, en[s]});
        wr(2'd2, 8'h01);
      end
    end

    // set beats clear
    wr(2'd3, 8'h01);
    @(negedge clk); wake_i = 4'h1;
    wr(2'd2, 8'h01);
    rd(2'd2, rv); check("R8 set wins", rv & 8'h01, 8'h01);
    wake_i = '0;
    wr(2'd2, 8'h01);
    rd(2'd2, rv); check("R8 cleared after", rv & 8'h01, 8'h00);

    // power-on falling edge, wake-select clear
    wr(2'd0, 8'h00);
    @(negedge clk); por_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd(2'd2, rv); check("R6 not yet at edge 2", rv & 8'h01, 8'h00);
    @(negedge clk);
    rd(2'd2, rv); check("R6 set at edge 3", rv & 8'h01, 8'h01);
    wr(2'd2, 8'h01);
    repeat (3) @(negedge clk);
    rd(2'd2, rv); check("R6 low level no reset", rv & 8'h01, 8'h00);
    por_ni = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd2, rv); check("R6 rising ignored", rv & 8'h01, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule